// File: doc/BRIEF.md
# Serial DAC Command Front End

This block is the digital front end of a single-channel voltage-output DAC. It listens on a three-wire serial port made of an active-low select/load line, a serial clock and a data line. It decodes a 4-bit command from each frame and keeps two code registers, a staging register and a live register, together with a power-down flag and a reference-select flag. The live code, the power-down flag and the reference choice go straight to the analog core. The analog converter, the output amplifier and the reference itself lie outside this block.

The three serial pins run asynchronously to the system clock `clk`. Each pin is synchronised through `SYNC_STAGES` flip-flops, and the block then looks for edges on the synchronised values. For this reason each serial clock phase, and the gap between frames, must last at least `SYNC_STAGES + 1` system clock periods. The serial port has no back-pressure: every frame that is correctly formed is acted on when the select line rises. The outputs toward the analog core are plain levels. `exec_stb` is a one-cycle pulse and carries no handshake.

The parameter `RES` sets the resolution to 12, 10 or 8 bits. The strap parameter `RESET_MID` sets the reset code: 0 gives zero, 1 gives midscale.

Top module: `dac_cmd_front`

## Requirements
- R1: After reset, `ref_supply` is 0 (internal reference), `pwr_down` is 0, and `dac_code` is 0 when `RESET_MID`=0 or 2^(RES-1) when `RESET_MID`=1. The staging register holds the same value as `dac_code`.
- R2: While `cs_n` is low, one bit of `sdi` is taken, MSB first, on each rising edge of `sck`. A 24-bit frame is laid out as bits [23:20] command, bits [19:16] ignored, and bits [15:0] data word. The new code is data word bits [15:16-RES]. The data word bits below that are ignored.
- R3: A 32-bit frame is also accepted. It is 8 ignored leading bits followed by the 24-bit layout of R2.
- R4: A command runs only when `cs_n` rises. If the number of `sck` rising edges counted while `cs_n` was low is neither 24 nor 32, nothing changes and no strobe is issued.
- R5: Command 4'b0000 loads the staging register only, so `dac_code` does not change. Command 4'b0001 copies the staging register to `dac_code` and clears `pwr_down`.
- R6: Command 4'b0011 loads the new code into both registers and clears `pwr_down`.
- R7: Command 4'b0100 sets `pwr_down`. Both registers keep their values while powered down. Command 0001 or 0011 brings the block out of power-down.
- R8: Command 4'b0110 clears `ref_supply` (internal reference). Command 4'b0111 sets it (supply as reference). Neither command uses the data word.
- R9: All other command codes (0010, 0101 and 1000 to 1111) change no state and issue no strobe.
- R10: `exec_stb` is high for exactly one `clk` cycle for each frame that runs a defined command.
- R11: `sck` edges while `cs_n` is high are not shifted or counted. The level of `sck` when `cs_n` falls does not matter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial select; low frames a transfer, and a rising edge executes the command |
| sck | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| dac_code | output | RES | Live code sent to the converter |
| pwr_down | output | 1 | High while the analog core is powered down |
| ref_supply | output | 1 | 1 = supply used as reference, 0 = internal reference |
| exec_stb | output | 1 | One-cycle pulse for each executed command |

## Verification
Two instances, one 12-bit with a zero reset code and one 8-bit with a midscale reset code, receive the same serial frames. A single data word therefore exposes any error in the left-justified field cut: if the slice is wrong, the two instances disagree. An update-with-write sweep covers all 256 values of the upper data byte, with fixed junk in the ignored bits, and alternates between 24-bit and 32-bit frames. This separates correct framing from correct alignment of the count. Focused sequences then exercise write-without-update, power-down with the registers retained, the reference commands with a junk data word, every reserved code, frames one bit short or one bit long, and `sck` activity while `cs_n` is high. Each sequence shows whether a given path changes state at the correct moment and leaves the rest untouched.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int WORD_W      = 16;
  localparam int FRAME_SHORT = 24;
  localparam int FRAME_LONG  = 32;

  typedef enum logic [3:0] {
    OP_WRITE   = 4'b0000,
    OP_UPDATE  = 4'b0001,
    OP_WRUPD   = 4'b0011,
    OP_PDOWN   = 4'b0100,
    OP_REF_INT = 4'b0110,
    OP_REF_VCC = 4'b0111
  } op_e;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int       STAGES  = 2,
  parameter bit       RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= RST_VAL;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter
  import dacfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  output logic              frame_ok,
  output logic [3:0]        frame_cmd,
  output logic [WORD_W-1:0] frame_word
);
  localparam int CNT_MAX = FRAME_LONG + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic                   cs_q, sck_q;
  logic [FRAME_SHORT-1:0] sh;
  logic [CNT_W-1:0]       cnt;
  logic                   sck_rise, cs_fall, cs_rise, len_ok;

  assign sck_rise = sck_s & ~sck_q & ~cs_s;
  assign cs_fall  = ~cs_s & cs_q;
  assign cs_rise  = cs_s & ~cs_q;
  assign len_ok   = (cnt == CNT_W'(FRAME_SHORT)) || (cnt == CNT_W'(FRAME_LONG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_s;
      sck_q <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else begin
      if (sck_rise) sh <= {sh[FRAME_SHORT-2:0], sdi_s};
      if (cs_fall)
        cnt <= sck_rise ? CNT_W'(1) : '0;
      else if (sck_rise && cnt != CNT_W'(CNT_MAX))
        cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) frame_ok <= 1'b0;
    else        frame_ok <= cs_rise & len_ok;

  assign frame_cmd  = sh[FRAME_SHORT-1 -: 4];
  assign frame_word = sh[WORD_W-1:0];

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(CNT_MAX)); // R4
  AST_NO_COUNT_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> $stable(cnt)); // R11
  AST_OK_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> cs_s); // R4
endmodule

// File: rtl/dacfe_exec.sv
module dacfe_exec
  import dacfe_pkg::*;
#(
  parameter int RES       = 12,
  parameter bit RESET_MID = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ok,
  input  logic [3:0]        frame_cmd,
  input  logic [WORD_W-1:0] frame_word,
  output logic [RES-1:0]    dac_code,
  output logic              pwr_down,
  output logic              ref_supply,
  output logic              exec_stb
);
  localparam logic [RES-1:0] RST_CODE = RESET_MID ? (RES'(1) << (RES-1)) : '0;

  logic [RES-1:0] in_reg, new_code;
  logic           is_update, is_defined;

  assign new_code   = frame_word[WORD_W-1 -: RES];
  assign is_update  = (frame_cmd == OP_UPDATE) || (frame_cmd == OP_WRUPD);
  assign is_defined = frame_cmd inside {OP_WRITE, OP_UPDATE, OP_WRUPD,
                                        OP_PDOWN, OP_REF_INT, OP_REF_VCC};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_reg     <= RST_CODE;
      dac_code   <= RST_CODE;
      pwr_down   <= 1'b0;
      ref_supply <= 1'b0;
      exec_stb   <= 1'b0;
    end else begin
      exec_stb <= 1'b0;
      if (frame_ok) begin
        case (frame_cmd)
          OP_WRITE: begin
            in_reg   <= new_code;
            exec_stb <= 1'b1;
          end
          OP_UPDATE: begin
            dac_code <= in_reg;
            pwr_down <= 1'b0;
            exec_stb <= 1'b1;
          end
          OP_WRUPD: begin
            in_reg   <= new_code;
            dac_code <= new_code;
            pwr_down <= 1'b0;
            exec_stb <= 1'b1;
          end
          OP_PDOWN: begin
            pwr_down <= 1'b1;
            exec_stb <= 1'b1;
          end
          OP_REF_INT: begin
            ref_supply <= 1'b0;
            exec_stb   <= 1'b1;
          end
          OP_REF_VCC: begin
            ref_supply <= 1'b1;
            exec_stb   <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |=> !exec_stb); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> $stable(dac_code) && $stable(in_reg) && !exec_stb); // R4
  AST_UPDATE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && is_update |=> !pwr_down); // R7
  AST_PDOWN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && frame_cmd == OP_PDOWN |=> pwr_down && $stable(dac_code) && $stable(in_reg)); // R7
  AST_RESERVED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && !is_defined |=> $stable(dac_code) && $stable(in_reg)
      && $stable(pwr_down) && $stable(ref_supply) && !exec_stb); // R9
  AST_WRITE_ONLY_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && frame_cmd == OP_WRITE |=> $stable(dac_code)); // R5
endmodule

// File: rtl/dac_cmd_front.sv
module dac_cmd_front
  import dacfe_pkg::*;
#(
  parameter int RES         = 12,
  parameter bit RESET_MID   = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           sck,
  input  logic           sdi,
  output logic [RES-1:0] dac_code,
  output logic           pwr_down,
  output logic           ref_supply,
  output logic           exec_stb
);
  logic              cs_s, sck_s, sdi_s;
  logic              frame_ok;
  logic [3:0]        frame_cmd;
  logic [WORD_W-1:0] frame_word;

  dacfe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
  dacfe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
    .clk(clk), .rst_n(rst_n), .d(sck), .q(sck_s));
  dacfe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s));

  dacfe_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_s(sck_s), .sdi_s(sdi_s),
    .frame_ok(frame_ok), .frame_cmd(frame_cmd), .frame_word(frame_word));

  dacfe_exec #(.RES(RES), .RESET_MID(RESET_MID)) u_exec (
    .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .frame_cmd(frame_cmd),
    .frame_word(frame_word), .dac_code(dac_code), .pwr_down(pwr_down),
    .ref_supply(ref_supply), .exec_stb(exec_stb));
endmodule

// File: tb/test_dac_cmd_front.sv
module test_dac_cmd_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [11:0] code12;
  logic [7:0]  code8;
  logic pd12, pd8, rs12, rs8, stb12, stb8;
  int n_chk = 0, n_bad = 0;
  int stb_cnt12 = 0, stb_cnt8 = 0;
  bit done = 0;

  // expected state: index 0 = 12-bit zero reset, 1 = 8-bit midscale reset
  logic [11:0] m_in12, m_dac12;
  logic [7:0]  m_in8, m_dac8;
  logic        m_pd, m_ref;

  always #2 clk = ~clk;

  dac_cmd_front i_dac_cmd_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .dac_code(code12), .pwr_down(pd12), .ref_supply(rs12), .exec_stb(stb12));

  dac_cmd_front #(.RES(8), .RESET_MID(1'b1)) i_dac_cmd_front_r8 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .dac_code(code8), .pwr_down(pd8), .ref_supply(rs8), .exec_stb(stb8));

  always @(posedge clk) begin
    if (stb12) stb_cnt12++;
    if (stb8)  stb_cnt8++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    chk({req, " code12"}, int'(code12), int'(m_dac12));
    chk({req, " code8"},  int'(code8),  int'(m_dac8));
    chk({req, " pd12"},   int'(pd12),   int'(m_pd));
    chk({req, " pd8"},    int'(pd8),    int'(m_pd));
    chk({req, " ref12"},  int'(rs12),   int'(m_ref));
    chk({req, " ref8"},   int'(rs8),    int'(m_ref));
  endtask

  // send n bits of v, MSB first; optional sck noise with cs high first
  task automatic send(input int n, input logic [63:0] v, input bit noise);
    if (noise) begin
      for (int k = 0; k < 6; k++) begin
        sdi = k[0]; sck = 1'b1; wclk(4); sck = 1'b0; wclk(4);
      end
      sck = 1'b1; wclk(4);
    end
    cs_n = 1'b0; wclk(4);
    if (noise) begin sck = 1'b0; wclk(4); end
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i]; wclk(3);
      sck = 1'b1; wclk(4);
      sck = 1'b0; wclk(1);
    end
    wclk(3);
    cs_n = 1'b1;
    wclk(12);
  endtask

  // expected-state update from the requirements
  function automatic bit model(input logic [3:0] c, input logic [15:0] w);
    case (c)
      4'b0000: begin m_in12 = w[15:4]; m_in8 = w[15:8]; return 1; end
      4'b0001: begin m_dac12 = m_in12; m_dac8 = m_in8; m_pd = 0; return 1; end
      4'b0011: begin m_in12 = w[15:4]; m_in8 = w[15:8];
                     m_dac12 = w[15:4]; m_dac8 = w[15:8]; m_pd = 0; return 1; end
      4'b0100: begin m_pd = 1; return 1; end
      4'b0110: begin m_ref = 0; return 1; end
      4'b0111: begin m_ref = 1; return 1; end
      default: return 0;
    endcase
  endfunction

  // n = 24 or 32 gives a legal frame; any other n is a bad length
  task automatic frame(input string req, input int n, input logic [3:0] c,
                       input logic [15:0] w, input bit noise);
    logic [63:0] v;
    int s12, s8;
    bit ex;
    v = {32'h0, 8'hC3, c, 4'hA, w};
    s12 = stb_cnt12; s8 = stb_cnt8;
    send(n, v, noise);
    ex = (n == 24 || n == 32) ? model(c, w) : 1'b0;
    check_all(req);
    chk({req, " stb12"}, stb_cnt12 - s12, int'(ex));
    chk({req, " stb8"},  stb_cnt8 - s8,   int'(ex));
  endtask

  initial begin
    m_in12 = 12'h000; m_dac12 = 12'h000;
    m_in8  = 8'h80;   m_dac8  = 8'h80;
    m_pd = 0; m_ref = 0;
    wclk(5);
    rst_n = 1'b1;
    wclk(3);
    check_all("R1 reset");
    // R1: staging register equals reset code -> plain update keeps it
    frame("R1 update-after-reset", 24, 4'b0001, 16'hFFFF, 0);

    // R2 R3 R6: sweep upper byte, junk in ignored bits, alternating length
    for (int k = 0; k < 256; k++)
      frame((k % 2) ? "R3 wrupd32" : "R2 wrupd24", (k % 2) ? 32 : 24,
            4'b0011, {k[7:0], 8'h5A}, 0);

    // R5: write only, then update
    frame("R5 write", 24, 4'b0000, 16'h3C7F, 0);
    frame("R5 update", 32, 4'b0001, 16'h0000, 0);

    // R7: power down keeps codes, write during pd, update wakes
    frame("R7 pdown", 24, 4'b0100, 16'hFFFF, 0);
    frame("R7 write-in-pd", 24, 4'b0000, 16'h9120, 0);
    frame("R7 pdown-again", 32, 4'b0100, 16'h0000, 0);
    frame("R7 update-wakes", 24, 4'b0001, 16'h0000, 0);
    frame("R7 pdown2", 24, 4'b0100, 16'h1234, 0);
    frame("R7 wrupd-wakes", 24, 4'b0011, 16'hE6D0, 0);

    // R8: reference select, data ignored
    frame("R8 ref-supply", 24, 4'b0111, 16'hABCD, 0);
    frame("R8 ref-internal", 32, 4'b0110, 16'h4321, 0);
    frame("R8 ref-supply2", 32, 4'b0111, 16'h0001, 0);

    // R9: every reserved code
    for (int c = 0; c < 16; c++)
      if (!(c inside {0, 1, 3, 4, 6, 7}))
        frame("R9 reserved", 24, c[3:0], 16'h7777, 0);

    // R4: wrong lengths discarded
    frame("R4 len23", 23, 4'b0011, 16'h1111, 0);
    frame("R4 len25", 25, 4'b0011, 16'h2222, 0);
    frame("R4 len31", 31, 4'b0011, 16'h3333, 0);
    frame("R4 len33", 33, 4'b0011, 16'h4444, 0);
    frame("R4 len0", 0, 4'b0011, 16'h5555, 0);

    // R11: sck noise with cs high, sck high at cs fall
    frame("R11 noise24", 24, 4'b0011, 16'hC350, 1);
    frame("R11 noise32", 32, 4'b0110, 16'h0000, 1);
    frame("R10 final", 24, 4'b0001, 16'h0000, 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule